// File: doc/BRIEF.md
# Serial Control Register with Output Steering

This block holds the eight-bit control word of a frequency synthesizer. The word is loaded through a three-wire serial port: a serial clock, a data line and an active-low enable. Bits are shifted in, most significant first, while the enable is low. The assembled word is committed when the enable returns high. All serial inputs are sampled by the system clock, so the serial clock must run well below it. Each serial phase must last at least two system clocks.

The committed bits do not go straight to the pins. A steering stage combines them with a standby request, with a two-bit mode code supplied by a neighbouring register, and with the raw lock indication. From these it produces registered controls: phase-detector polarity and enables, the lock-detect pin, the standby request, the charge-current code and step size, a general-purpose port value, and an open-drain style output given as an enable/data pair.

Top module: `synth_ctl_reg`

## Requirements
- R1: The word is shifted most significant bit first. The bit taken on the first serial clock lands in bit 7 and the bit on the eighth lands in bit 0. Bit meanings: 7 polarity, 6 detector-A select, 5 lock-detect enable, 4 standby, 3:2 current code, 1 port/step bit, 0 output-B release.
- R2: The word is committed only on the rising edge of `ser_en_n`. If more than eight serial clocks occurred while the enable was low, only the last eight bits shifted in are kept.
- R3: An enable pulse that carries fewer than eight serial clocks, including none, leaves the committed word and every output unchanged.
- R4: After synchronous reset the word is all zeros. The outputs are then: `pol_inv`=0, `pda_en`=0, `pdb_en`=1, `lock_out`=0, `standby`=0, `cur_code`=0, `cur_max`=0, `step_25`=0, `outa_val`=0, `outb_oe`=1, `outb_dat`=0.
- R5: With bit 5 clear, `lock_out` is 0. With bits 5 and 4 both set, `lock_out` is 1. With bit 5 set and bit 4 clear, `lock_out` follows `lock_raw` one clock later.
- R6: When `porta_mode` equals 2'b01 (port mode), `outa_val` equals bit 1 and `step_25` is 0. For any other code, `outa_val` is 0 and `step_25` equals bit 1. Standby has no effect on either.
- R7: Bit 0 set gives `outb_oe`=0 (high impedance). Bit 0 clear gives `outb_oe`=1 with `outb_dat`=0. Standby has no effect on this.
- R8: `pol_inv` equals bit 7 and `standby` equals bit 4. `pda_en` is bit 6 AND NOT bit 4. `pdb_en` is NOT bit 6 AND NOT bit 4. `cur_code` equals bits 3:2, and `cur_max` is 1 exactly when both of those bits are 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial shift clock, data taken on its rising edge |
| ser_en_n | input | 1 | Active-low serial enable; its rising edge commits the word |
| ser_din | input | 1 | Serial data, MSB first |
| porta_mode | input | 2 | Output-A function code from another register; 2'b01 = port |
| lock_raw | input | 1 | Raw lock indication from the lock detector |
| pol_inv | output | 1 | Detector polarity invert |
| pda_en | output | 1 | Enable for detector A |
| pdb_en | output | 1 | Enable for detector B |
| lock_out | output | 1 | Gated lock-detect pin value |
| standby | output | 1 | Standby request |
| cur_code | output | 2 | Charge-current code |
| cur_max | output | 1 | Maximum current selected |
| step_25 | output | 1 | 25% current steps when 1, 10% when 0 |
| outa_val | output | 1 | Output-A level when in port mode |
| outb_oe | output | 1 | Output-B drive enable |
| outb_dat | output | 1 | Output-B drive value (always low) |

## Verification
A wrong shift order or a wrong bit count shows at the ports about four system clocks after the enable rises. The fields land in the wrong outputs, or a short frame overwrites a word that should have survived. Wrong steering shows as an illegal pair of outputs one clock after the word or the mode input changes: both detectors enabled, the lock pin high with its enable clear, or output B driven while its release bit is set. The tests write words that isolate each field and its gating. They also cover frames that are too long, too short and empty, and they check every output after each step.

// File: rtl/sctl_pkg.sv
package sctl_pkg;
  typedef struct packed {
    logic       pol;
    logic       det_a;
    logic       lde;
    logic       stby;
    logic [1:0] cur;
    logic       port_bit;
    logic       outb_hiz;
  } ctl_word_t;

  localparam int unsigned CTL_W = $bits(ctl_word_t);
  localparam logic [1:0]  MODE_PORT = 2'b01;
endpackage

// File: rtl/sctl_shift.sv
module sctl_shift #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ser_clk,
  input  logic         ser_en_n,
  input  logic         ser_din,
  output logic [W-1:0] word
);
  localparam int unsigned CNT_W = $clog2(W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(W);

  logic clk_q, clk_d, en_q, en_d, din_q;
  logic [W-1:0] sh;
  logic [CNT_W-1:0] cnt;
  logic shift_evt, commit_evt;

  assign shift_evt  = clk_q && !clk_d && !en_q;
  assign commit_evt = en_q && !en_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      clk_q <= 1'b0;
      clk_d <= 1'b0;
      en_q  <= 1'b1;
      en_d  <= 1'b1;
      din_q <= 1'b0;
    end else begin
      clk_q <= ser_clk;
      clk_d <= clk_q;
      en_q  <= ser_en_n;
      en_d  <= en_q;
      din_q <= ser_din;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sh  <= '0;
      cnt <= '0;
    end else if (en_q) begin
      cnt <= '0;
    end else if (shift_evt) begin
      sh <= {sh[W-2:0], din_q};
      if (cnt != FULL) cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) word <= '0;
    else if (commit_evt && cnt == FULL) word <= sh;
  end

  // R3
  word_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(commit_evt && cnt == FULL) |=> $stable(word));

  // R2
  cnt_sat_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= FULL);
endmodule

// File: rtl/sctl_steer.sv
module sctl_steer
  import sctl_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  ctl_word_t  cw,
  input  logic [1:0] porta_mode,
  input  logic       lock_raw,
  output logic       pol_inv,
  output logic       pda_en,
  output logic       pdb_en,
  output logic       lock_out,
  output logic       standby,
  output logic [1:0] cur_code,
  output logic       cur_max,
  output logic       step_25,
  output logic       outa_val,
  output logic       outb_oe,
  output logic       outb_dat
);
  logic is_port;
  assign is_port = (porta_mode == MODE_PORT);

  always_ff @(posedge clk) begin
    if (rst) begin
      pol_inv  <= 1'b0;
      pda_en   <= 1'b0;
      pdb_en   <= 1'b1;
      lock_out <= 1'b0;
      standby  <= 1'b0;
      cur_code <= 2'b00;
      cur_max  <= 1'b0;
      step_25  <= 1'b0;
      outa_val <= 1'b0;
      outb_oe  <= 1'b1;
      outb_dat <= 1'b0;
    end else begin
      pol_inv  <= cw.pol;
      pda_en   <= cw.det_a && !cw.stby;
      pdb_en   <= !cw.det_a && !cw.stby;
      lock_out <= cw.lde && (cw.stby || lock_raw);
      standby  <= cw.stby;
      cur_code <= cw.cur;
      cur_max  <= &cw.cur;
      step_25  <= !is_port && cw.port_bit;
      outa_val <= is_port && cw.port_bit;
      outb_oe  <= !cw.outb_hiz;
      outb_dat <= 1'b0;
    end
  end

  // R5
  lock_off_chk: assert property (@(posedge clk) disable iff (rst)
    !cw.lde |=> !lock_out);

  // R5
  lock_stby_chk: assert property (@(posedge clk) disable iff (rst)
    (cw.lde && cw.stby) |=> lock_out);

  // R6
  port_step_chk: assert property (@(posedge clk) disable iff (rst)
    is_port |=> !step_25);

  // R7
  outb_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (outb_oe != $past(cw.outb_hiz)) && !outb_dat);

  // R8
  det_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({pda_en, pdb_en}));
endmodule

// File: rtl/synth_ctl_reg.sv
module synth_ctl_reg
  import sctl_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       ser_clk,
  input  logic       ser_en_n,
  input  logic       ser_din,
  input  logic [1:0] porta_mode,
  input  logic       lock_raw,
  output logic       pol_inv,
  output logic       pda_en,
  output logic       pdb_en,
  output logic       lock_out,
  output logic       standby,
  output logic [1:0] cur_code,
  output logic       cur_max,
  output logic       step_25,
  output logic       outa_val,
  output logic       outb_oe,
  output logic       outb_dat
);
  logic [CTL_W-1:0] word;
  ctl_word_t cw;

  sctl_shift #(.W(CTL_W)) u_shift (
    .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_en_n(ser_en_n),
    .ser_din(ser_din), .word(word)
  );

  assign cw = ctl_word_t'(word);

  sctl_steer u_steer (
    .clk(clk), .rst(rst), .cw(cw), .porta_mode(porta_mode),
    .lock_raw(lock_raw), .pol_inv(pol_inv), .pda_en(pda_en),
    .pdb_en(pdb_en), .lock_out(lock_out), .standby(standby),
    .cur_code(cur_code), .cur_max(cur_max), .step_25(step_25),
    .outa_val(outa_val), .outb_oe(outb_oe), .outb_dat(outb_dat)
  );
endmodule

// File: tb/tb_synth_ctl_reg.sv
module tb_synth_ctl_reg;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ser_clk = 1'b0, ser_en_n = 1'b1, ser_din = 1'b0;
  logic [1:0] porta_mode = 2'b00;
  logic lock_raw = 1'b0;
  logic pol_inv, pda_en, pdb_en, lock_out, standby, cur_max, step_25;
  logic outa_val, outb_oe, outb_dat;
  logic [1:0] cur_code;
  int checks = 0, errors = 0;
  logic [7:0] model = 8'h00;

  always #10 clk = ~clk;

  synth_ctl_reg dut (
    .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_en_n(ser_en_n),
    .ser_din(ser_din), .porta_mode(porta_mode), .lock_raw(lock_raw),
    .pol_inv(pol_inv), .pda_en(pda_en), .pdb_en(pdb_en),
    .lock_out(lock_out), .standby(standby), .cur_code(cur_code),
    .cur_max(cur_max), .step_25(step_25), .outa_val(outa_val),
    .outb_oe(outb_oe), .outb_dat(outb_dat)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // shift the low n bits of v, MSB first, in one enable window
  task automatic send_bits(input logic [15:0] v, input int n);
    ser_en_n = 1'b0;
    wait_clk(2);
    for (int i = n - 1; i >= 0; i--) begin
      ser_din = v[i];
      wait_clk(2);
      ser_clk = 1'b1;
      wait_clk(2);
      ser_clk = 1'b0;
    end
    wait_clk(2);
    ser_en_n = 1'b1;
    wait_clk(6);
  endtask

  task automatic write_word(input logic [7:0] b);
    send_bits({8'h00, b}, 8);
    model = b;
  endtask

  // expected outputs computed from the model word per R5..R8
  task automatic check_all(input string tag);
    logic port;
    port = (porta_mode == 2'b01);
    chk({tag, " R8 pol"},  {7'd0, pol_inv}, {7'd0, model[7]});
    chk({tag, " R8 pda"},  {7'd0, pda_en},  {7'd0, model[6] & ~model[4]});
    chk({tag, " R8 pdb"},  {7'd0, pdb_en},  {7'd0, ~model[6] & ~model[4]});
    chk({tag, " R8 stby"}, {7'd0, standby}, {7'd0, model[4]});
    chk({tag, " R8 cur"},  {6'd0, cur_code}, {6'd0, model[3:2]});
    chk({tag, " R8 max"},  {7'd0, cur_max}, {7'd0, &model[3:2]});
    chk({tag, " R5 lock"}, {7'd0, lock_out}, {7'd0, model[5] & (model[4] | lock_raw)});
    chk({tag, " R6 step"}, {7'd0, step_25}, {7'd0, ~port & model[1]});
    chk({tag, " R6 outa"}, {7'd0, outa_val}, {7'd0, port & model[1]});
    chk({tag, " R7 oe"},   {7'd0, outb_oe}, {7'd0, ~model[0]});
    chk({tag, " R7 dat"},  {7'd0, outb_dat}, 8'd0);
  endtask

  task automatic t_reset;
    // R4 reset state
    check_all("R4 reset");
  endtask

  task automatic t_fields;
    // R1 order and mapping
    write_word(8'hC9);
    check_all("R1 C9");
    write_word(8'h36);
    check_all("R1 36");
  endtask

  task automatic t_long_frame;
    // R2 ten clocks keep the last eight
    send_bits(16'h02A5 | 16'h0100, 10);
    model = 8'hA5;
    check_all("R2 long");
  endtask

  task automatic t_short_frame;
    // R3 short and empty frames ignored
    send_bits(16'h001F, 5);
    check_all("R3 short");
    send_bits(16'h0000, 0);
    check_all("R3 empty");
  endtask

  task automatic t_lock;
    // R5 lock gating
    write_word(8'h20);
    lock_raw = 1'b1; wait_clk(3);
    check_all("R5 follow hi");
    lock_raw = 1'b0; wait_clk(3);
    check_all("R5 follow lo");
    write_word(8'h30);
    check_all("R5 stby hi");
    write_word(8'h10);
    lock_raw = 1'b1; wait_clk(3);
    check_all("R5 off");
    lock_raw = 1'b0;
  endtask

  task automatic t_port;
    // R6 port mode steering, unaffected by standby
    write_word(8'h02);
    porta_mode = 2'b01; wait_clk(3);
    check_all("R6 port");
    porta_mode = 2'b10; wait_clk(3);
    check_all("R6 step");
    porta_mode = 2'b01;
    write_word(8'h12);
    check_all("R6 port stby");
    porta_mode = 2'b00; wait_clk(3);
  endtask

  task automatic t_outb;
    // R7 output B in and out of standby; R8 max current
    write_word(8'h11);
    check_all("R7 hiz stby");
    write_word(8'h10);
    check_all("R7 low stby");
    write_word(8'h4C);
    check_all("R8 max");
  endtask

  initial begin
    wait_clk(4);
    rst = 1'b0;
    wait_clk(2);
    t_reset();
    t_fields();
    t_long_frame();
    t_short_frame();
    t_lock();
    t_port();
    t_outb();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule